// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps an asynchronous DRAM alive. After reset it holds the array idle for a programmable power-up pause. It then runs a burst of warm-up refresh cycles and raises a ready flag. From then on it counts refresh intervals and asks the access controller for the strobes whenever a refresh is owed. Each refresh is a CAS-before-RAS cycle, so the device's internal row counter supplies the address. The write strobe is held high throughout, because a low write strobe at the RAS edge of such a cycle would put the device into test mode.

The host controller sees a request/grant pair. The scheduler drives the RAS, CAS and WE strobes only while it owns them. A backlog of owed refreshes builds up while the host keeps the grant back. When the backlog reaches its limit, an urgent flag tells the host that it must yield. A sleep input, once granted, holds the device in self-refresh for at least a minimum time. Leaving sleep runs a recovery precharge and a burst of refresh cycles before normal service resumes. All timings are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset `ready_o` is low and all strobes are high for INIT_PAUSE_CYC cycles. WARMUP_CNT back-to-back refresh cycles follow. `ready_o` rises in the first cycle after the last warm-up precharge.
- R2: While `ready_o` is high, one refresh becomes owed every REF_INTERVAL cycles. `req_o` is high whenever the scheduler is idle and a refresh is owed or `sleep_i` is high.
- R3: A refresh cycle drives, in order: CAS low with RAS high for CSR_CYC cycles, both low for RAS_LOW_CYC cycles, then both high for PRECH_CYC cycles. CAS never rises while RAS is still low.
- R4: WE is high in every cycle. When `own_o` is low, RAS and CAS are high as well.
- R5: A grant given while `req_o` is high and `sleep_i` is low starts a refresh in the next cycle (`own_o` high) and retires one owed refresh. `req_o` drops once nothing is owed.
- R6: The count of owed refreshes saturates at MAX_BACKLOG. `urgent_o` is high exactly while the count is at that limit.
- R7: A grant given while `sleep_i` is high enters self-refresh. This is CAS low for CSR_CYC cycles, then RAS and CAS low until `sleep_i` is low and at least SREF_HOLD_CYC cycles have passed. `ready_o` is low throughout, and the owed count is cleared.
- R8: On leaving self-refresh, both strobes stay high for SREF_EXIT_CYC cycles. BURST_CNT refresh cycles follow, then `ready_o` rises again with nothing owed.
- R9: A grant given while `req_o` is low starts nothing: `own_o` and the strobes keep their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Request to enter and remain in self-refresh |
| grant_i | input | 1 | Host hands the strobes over to the scheduler |
| req_o | output | 1 | Scheduler needs the strobes |
| urgent_o | output | 1 | Owed refresh count at its limit; host must yield |
| ready_o | output | 1 | Initialisation complete and not sleeping |
| own_o | output | 1 | Scheduler is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low (held high) |

## Verification
The bench models the scheduler cycle by cycle and compares every strobe and flag on every clock. It targets these corner cases:
- The count of warm-up cycles. A miscount would raise ready early or late.
- A refresh owed on the same clock as one is retired. A wrong update would leak or double-count a refresh.
- Saturation of the backlog under a host that withholds the grant for many intervals. An off-by-one would raise the urgent flag one interval early or never.
- A sleep pulse shorter than the minimum self-refresh time. A design that ignores the floor would release RAS too soon.
- Spurious grants with no request pending. A design that honours them would start a cycle on the host's bus.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_IDLE,
      ST_CSR,
      ST_RASLO,
      ST_PRE,
      ST_SR_CSR,
      ST_SR_HOLD,
      ST_SR_EXIT
   } rfsh_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bits_for(input int v);
      return (v > 1) ? $clog2(v + 1) : 1;
   endfunction

endpackage

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
   parameter int INTERVAL    = 1950,
   parameter int MAX_BACKLOG = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic retire,
   input  logic clear,
   output logic owed,
   output logic urgent
);
   localparam int PW = dram_refresh_pkg::bits_for(MAX_BACKLOG);
   localparam int IW = dram_refresh_pkg::bits_for(INTERVAL);
   localparam logic [PW-1:0] P_MAX = PW'(MAX_BACKLOG);
   localparam logic [IW-1:0] I_LAST = IW'(INTERVAL - 1);

   logic          tick;
   logic [PW-1:0] pend_q;

   generate
      if (INTERVAL == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         logic [IW-1:0] itv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              itv_q <= '0;
            else if (!run)           itv_q <= '0;
            else if (itv_q == I_LAST) itv_q <= '0;
            else                     itv_q <= itv_q + IW'(1);
         end
         assign tick = run && (itv_q == I_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (clear) begin
         pend_q <= '0;
      end else begin
         unique case ({tick, retire})
            2'b10:   if (pend_q != P_MAX) pend_q <= pend_q + PW'(1);
            2'b01:   pend_q <= pend_q - PW'(1);
            default: pend_q <= pend_q;
         endcase
      end
   end

   assign owed   = (pend_q != '0);
   assign urgent = run && (pend_q == P_MAX);
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
   import dram_refresh_pkg::*;
#(
   parameter int INIT_PAUSE_CYC = 25000,
   parameter int WARMUP_CNT     = 8,
   parameter int CSR_CYC        = 1,
   parameter int RAS_LOW_CYC    = 8,
   parameter int PRECH_CYC      = 5,
   parameter int SREF_HOLD_CYC  = 12500,
   parameter int SREF_EXIT_CYC  = 14,
   parameter int BURST_CNT      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   input  logic start_ref,
   input  logic start_sr,
   output logic idle,
   output logic ready,
   output logic own,
   output logic ras_n,
   output logic cas_n
);
   localparam int TMAX = max2(max2(max2(INIT_PAUSE_CYC, SREF_HOLD_CYC),
                                   max2(RAS_LOW_CYC, PRECH_CYC)),
                              max2(CSR_CYC, SREF_EXIT_CYC));
   localparam int TW = bits_for(TMAX);
   localparam int LW = bits_for(max2(WARMUP_CNT, BURST_CNT));
   localparam logic [TW-1:0] K_PAUSE = TW'(INIT_PAUSE_CYC - 1);
   localparam logic [TW-1:0] K_CSR   = TW'(CSR_CYC - 1);
   localparam logic [TW-1:0] K_RAS   = TW'(RAS_LOW_CYC - 1);
   localparam logic [TW-1:0] K_PRE   = TW'(PRECH_CYC - 1);
   localparam logic [TW-1:0] K_HOLD  = TW'(SREF_HOLD_CYC - 1);
   localparam logic [TW-1:0] K_EXIT  = TW'(SREF_EXIT_CYC - 1);

   rfsh_state_e   state_q, state_d;
   logic [TW-1:0] tmr_q, tmr_d;
   logic [LW-1:0] left_q, left_d;
   logic          rdy_q, rdy_d;
   logic          ras_q, cas_q, own_q;
   logic          tdone;

   assign tdone = (tmr_q == '0);

   always_comb begin
      state_d = state_q;
      tmr_d   = tdone ? tmr_q : tmr_q - TW'(1);
      left_d  = left_q;
      rdy_d   = rdy_q;
      unique case (state_q)
         ST_PAUSE:
            if (tdone) begin state_d = ST_CSR; tmr_d = K_CSR; end
         ST_CSR:
            if (tdone) begin state_d = ST_RASLO; tmr_d = K_RAS; end
         ST_RASLO:
            if (tdone) begin state_d = ST_PRE; tmr_d = K_PRE; end
         ST_PRE:
            if (tdone) begin
               if (left_q > LW'(1)) begin
                  left_d  = left_q - LW'(1);
                  state_d = ST_CSR;
                  tmr_d   = K_CSR;
               end else begin
                  state_d = ST_IDLE;
                  rdy_d   = 1'b1;
               end
            end
         ST_IDLE:
            if (start_sr) begin
               state_d = ST_SR_CSR;
               tmr_d   = K_CSR;
               rdy_d   = 1'b0;
            end else if (start_ref) begin
               state_d = ST_CSR;
               tmr_d   = K_CSR;
               left_d  = LW'(1);
            end
         ST_SR_CSR:
            if (tdone) begin state_d = ST_SR_HOLD; tmr_d = K_HOLD; end
         ST_SR_HOLD:
            if (tdone && !sleep) begin state_d = ST_SR_EXIT; tmr_d = K_EXIT; end
         ST_SR_EXIT:
            if (tdone) begin
               state_d = ST_CSR;
               tmr_d   = K_CSR;
               left_d  = LW'(BURST_CNT);
            end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PAUSE;
         tmr_q   <= K_PAUSE;
         left_q  <= LW'(WARMUP_CNT);
         rdy_q   <= 1'b0;
         ras_q   <= 1'b1;
         cas_q   <= 1'b1;
         own_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         tmr_q   <= tmr_d;
         left_q  <= left_d;
         rdy_q   <= rdy_d;
         ras_q   <= !(state_d inside {ST_RASLO, ST_SR_HOLD});
         cas_q   <= !(state_d inside {ST_CSR, ST_RASLO, ST_SR_CSR, ST_SR_HOLD});
         own_q   <= !(state_d inside {ST_PAUSE, ST_IDLE});
      end
   end

   assign idle  = (state_q == ST_IDLE);
   assign ready = rdy_q;
   assign own   = own_q;
   assign ras_n = ras_q;
   assign cas_n = cas_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int INIT_PAUSE_CYC = 25000,
   parameter int WARMUP_CNT     = 8,
   parameter int REF_INTERVAL   = 1950,
   parameter int MAX_BACKLOG    = 8,
   parameter int CSR_CYC        = 1,
   parameter int RAS_LOW_CYC    = 8,
   parameter int PRECH_CYC      = 5,
   parameter int SREF_HOLD_CYC  = 12500,
   parameter int SREF_EXIT_CYC  = 14,
   parameter int BURST_CNT      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic grant_i,
   output logic req_o,
   output logic urgent_o,
   output logic ready_o,
   output logic own_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic we_n_o
);
   generate
      if (INIT_PAUSE_CYC < 1 || WARMUP_CNT < 1 || REF_INTERVAL < 1 ||
          MAX_BACKLOG < 1 || CSR_CYC < 1 || RAS_LOW_CYC < 1 ||
          PRECH_CYC < 1 || SREF_HOLD_CYC < 1 || BURST_CNT < 1) begin : g_bad_zero
         $error("dram_refresh_sched: every count and timing must be at least 1");
      end
      if (SREF_EXIT_CYC < PRECH_CYC) begin : g_bad_exit
         $error("dram_refresh_sched: self-refresh exit shorter than precharge");
      end
   endgenerate

   logic idle, ready, owed, urgent, start_ref, start_sr;

   assign req_o     = ready && idle && (owed || sleep_i);
   assign start_sr  = req_o && grant_i && sleep_i;
   assign start_ref = req_o && grant_i && !sleep_i;

   rfsh_backlog #(
      .INTERVAL    (REF_INTERVAL),
      .MAX_BACKLOG (MAX_BACKLOG)
   ) u_backlog (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ready),
      .retire (start_ref),
      .clear  (start_sr),
      .owed   (owed),
      .urgent (urgent)
   );

   rfsh_strobe_seq #(
      .INIT_PAUSE_CYC (INIT_PAUSE_CYC),
      .WARMUP_CNT     (WARMUP_CNT),
      .CSR_CYC        (CSR_CYC),
      .RAS_LOW_CYC    (RAS_LOW_CYC),
      .PRECH_CYC      (PRECH_CYC),
      .SREF_HOLD_CYC  (SREF_HOLD_CYC),
      .SREF_EXIT_CYC  (SREF_EXIT_CYC),
      .BURST_CNT      (BURST_CNT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (sleep_i),
      .start_ref (start_ref),
      .start_sr  (start_sr),
      .idle      (idle),
      .ready     (ready),
      .own       (own_o),
      .ras_n     (ras_n_o),
      .cas_n     (cas_n_o)
   );

   assign urgent_o = urgent;
   assign ready_o  = ready;
   assign we_n_o   = 1'b1;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
   parameter int RAS_LOW_CYC = 8,
   parameter int PRECH_CYC   = 5
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n_o,
   input logic cas_n_o,
   input logic own_o,
   input logic ready_o,
   input logic req_o
);
   int unsigned lo_cnt, hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= 0;
         hi_cnt <= 0;
      end else begin
         lo_cnt <= ras_n_o ? 0 : ((lo_cnt == 32'hFFFF_FFFF) ? lo_cnt : lo_cnt + 1);
         hi_cnt <= !ras_n_o ? 0 : ((hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1);
      end
   end

   AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o))); // R3
   AST_CAS_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n_o) |-> ras_n_o); // R3
   AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> (lo_cnt >= RAS_LOW_CYC)); // R3
   AST_PRECH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (hi_cnt >= PRECH_CYC)); // R3
   AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !own_o |-> (ras_n_o && cas_n_o)); // R4
   AST_REQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (ready_o && !own_o)); // R2
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
   .RAS_LOW_CYC (RAS_LOW_CYC),
   .PRECH_CYC   (PRECH_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ras_n_o (ras_n_o),
   .cas_n_o (cas_n_o),
   .own_o   (own_o),
   .ready_o (ready_o),
   .req_o   (req_o)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
   localparam int PAUSE = 20, WARM = 8, INTV = 40, MAXB = 8;
   localparam int CSR = 1, RASL = 8, PRE = 5, HOLD = 30, EXITC = 14, BURST = 4;
   localparam int CYC = CSR + RASL + PRE;

   logic clk = 0, rst_n = 0, sleep_i = 0, grant_i;
   logic req_o, urgent_o, ready_o, own_o, ras_n_o, cas_n_o, we_n_o;
   logic hold_off = 0, spur = 0;
   int n_chk = 0, n_fail = 0, cycles = 0;
   bit started = 0, seen_ready = 0, seen_urgent = 0;
   int init_falls = 0;
   logic prev_ras = 1;

   always #4 clk = ~clk;

   assign grant_i = spur | (req_o & (!hold_off | urgent_o));

   dram_refresh_sched #(
      .INIT_PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .REF_INTERVAL(INTV),
      .MAX_BACKLOG(MAXB), .CSR_CYC(CSR), .RAS_LOW_CYC(RASL), .PRECH_CYC(PRE),
      .SREF_HOLD_CYC(HOLD), .SREF_EXIT_CYC(EXITC), .BURST_CNT(BURST)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .grant_i(grant_i),
      .req_o(req_o), .urgent_o(urgent_o), .ready_o(ready_o), .own_o(own_o),
      .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
   );

   // reference model: mode 0 pause, 1 idle, 2 refresh cycle, 3 self-refresh
   int m_mode, m_sub, m_pos, m_left, m_pend, m_itv;
   bit m_ready;

   task automatic model_reset();
      m_mode = 0; m_sub = 0; m_pos = 0; m_left = WARM;
      m_pend = 0; m_itv = 0; m_ready = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit e_req, tick, retire, clr;
         e_req  = m_ready && m_mode == 1 && (m_pend > 0 || sleep_i);
         tick   = m_ready && (m_itv == INTV - 1);
         retire = 0; clr = 0;
         m_itv  = m_ready ? (tick ? 0 : m_itv + 1) : 0;
         case (m_mode)
            0: if (m_pos == PAUSE - 1) begin m_mode = 2; m_pos = 0; end else m_pos++;
            2: if (m_pos == CYC - 1) begin
                  if (m_left > 1) begin m_left--; m_pos = 0; end
                  else begin m_mode = 1; m_ready = 1; end
               end else m_pos++;
            1: if (e_req && grant_i) begin
                  if (sleep_i) begin m_mode = 3; m_sub = 0; m_pos = 0; m_ready = 0; clr = 1; end
                  else begin m_mode = 2; m_pos = 0; m_left = 1; retire = 1; end
               end
            default: begin
               if (m_sub == 0) begin
                  if (m_pos == CSR - 1) begin m_sub = 1; m_pos = 0; end else m_pos++;
               end else if (m_sub == 1) begin
                  if (m_pos >= HOLD - 1 && !sleep_i) begin m_sub = 2; m_pos = 0; end
                  else if (m_pos < HOLD) m_pos++;
               end else begin
                  if (m_pos == EXITC - 1) begin m_mode = 2; m_pos = 0; m_left = BURST; end
                  else m_pos++;
               end
            end
         endcase
         if (clr) m_pend = 0;
         else begin
            m_pend = m_pend + int'(tick) - int'(retire);
            if (m_pend > MAXB) m_pend = MAXB;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         int e_ras, e_cas, e_own, e_req, e_urg;
         e_ras = 1; e_cas = 1; e_own = 0;
         if (m_mode == 2) begin
            e_own = 1;
            if (m_pos < CSR) e_cas = 0;
            else if (m_pos < CSR + RASL) begin e_cas = 0; e_ras = 0; end
         end else if (m_mode == 3) begin
            e_own = 1;
            if (m_sub == 0) e_cas = 0;
            else if (m_sub == 1) begin e_cas = 0; e_ras = 0; end
         end
         e_req = (m_ready && m_mode == 1 && (m_pend > 0 || sleep_i)) ? 1 : 0;
         e_urg = (m_ready && m_pend >= MAXB) ? 1 : 0;
         check(ras_n_o == e_ras, "R3/R7/R8 ras_n", int'(ras_n_o), e_ras);
         check(cas_n_o == e_cas, "R3/R7/R8 cas_n", int'(cas_n_o), e_cas);
         check(we_n_o == 1'b1, "R4 we_n", int'(we_n_o), 1);
         check(own_o == e_own, "R5/R9 own", int'(own_o), e_own);
         check(ready_o == m_ready, "R1/R8 ready", int'(ready_o), int'(m_ready));
         check(req_o == e_req, "R2/R5 req", int'(req_o), e_req);
         check(urgent_o == e_urg, "R6 urgent", int'(urgent_o), e_urg);
         if (!seen_ready && prev_ras && !ras_n_o) init_falls++;
         if (!seen_ready && ready_o) begin
            seen_ready = 1;
            check(init_falls == WARM, "R1 warm-up count", init_falls, WARM);
         end
         if (urgent_o) seen_urgent = 1;
         prev_ras = ras_n_o;
      end
   end

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      @(posedge clk); started = 1;
      run(4);
      check(ras_n_o && cas_n_o && !ready_o && !own_o, "R1 reset state",
            int'({ras_n_o, cas_n_o, ready_o, own_o}), 4'b1100);
      rst_n = 1;
      run(PAUSE + WARM * CYC + 5);
      run(200);
      spur = 1; run(60); spur = 0;
      hold_off = 1; run(600);
      check(seen_urgent, "R6 urgent seen", int'(seen_urgent), 1);
      hold_off = 0; run(300);
      sleep_i = 1; run(100); sleep_i = 0; run(150);
      sleep_i = 1; run(5); sleep_i = 0; run(200);
      check(ready_o, "R8 ready after wake", int'(ready_o), 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule